// File: doc/BRIEF.md
# Direct-Mapped Read Cache with Region Flush

This block is a word-granular read cache placed between a processor port and a slower memory. Each line stores one 32-bit word, a short tag and a valid bit. The index field of the address picks exactly one line, so a lookup needs one tag comparison. The data read happens in the same cycle as the comparison, and a read hit completes combinationally. A read miss fetches the word over a request/acknowledge memory port. It fills the chosen line and hands the word back in the acknowledge cycle. Writes always pass through to memory. A write that hits refreshes the cached word. A write that misses leaves the cache unchanged.

Lines do not store the full upper address. A single region register holds the topmost address field. When an access arrives whose region field differs from the held value, the block first sweeps the whole index space, one line per cycle, and clears every valid bit. During the sweep it raises busy and holds the processor off. After the sweep it loads the new region and serves the pending access as a miss. The address is split, from bit 0 upward, into a 2-bit byte offset, the index, an 8-bit tag and an 8-bit region field. Any bits above the region field are ignored.

The processor raises `req_i` with stable `we_i`, `addr_i` and `wdata_i`. It holds them until `ready_o` is high for one cycle, then drops `req_i` for at least one cycle. The memory side answers each held `mem_req_o` with a single-cycle `mem_ack_i`.

Top module: `dm_region_cache`

## Requirements
- R1: A read whose line is valid, whose stored tag equals the address tag field and whose region field equals the held region completes in its first cycle. In that cycle `ready_o` is high, `mem_req_o` is low and `rdata_o` holds the cached word.
- R2: A read that misses raises `mem_req_o` with `mem_we_o` low and `mem_addr_o` equal to `addr_i[ADDR_W-1:2]`. It holds the request until `mem_ack_i`. In the acknowledge cycle `ready_o` is high and `rdata_o` equals `mem_rdata_i`.
- R3: After a read miss fills a line, a later read of the same word address with no intervening flush hits and returns the filled word.
- R4: Two addresses with the same index but different tags evict each other, so alternating reads of them miss every time.
- R5: An access whose region field (bits `IDX_W+17:IDX_W+10`) differs from the held region raises `busy_o` for exactly 2^IDX_W cycles. During those cycles there is no memory request and no `ready_o`. Afterwards every line is invalid, so any read misses until it is refilled.
- R6: The first access after reset loads the region register without a sweep, so `busy_o` stays low.
- R7: Every write raises `mem_req_o` with `mem_we_o` high, the word address on `mem_addr_o` and `wdata_i` on `mem_wdata_o`. It completes with `ready_o` only in the `mem_ack_i` cycle.
- R8: A write that hits replaces the cached word, so a following read hits and returns the written data.
- R9: A write that misses allocates no line, so a following read of that address misses.
- R10: During and right after reset, `ready_o`, `busy_o` and `mem_req_o` are low and every line is invalid.
- R11: Byte-offset bits `addr_i[1:0]` and all bits above the region field have no effect on lookup or hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Processor access request, held until ready |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, valid with ready_o on reads |
| ready_o | output | 1 | Access completes this cycle |
| busy_o | output | 1 | Region sweep in progress |
| mem_req_o | output | 1 | Memory request, held until acknowledge |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | ADDR_W-2 | Memory word address |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_rdata_i | input | DATA_W | Memory read data, valid with mem_ack_i |
| mem_ack_i | input | 1 | Memory acknowledge, one cycle |

## Verification
A stale valid bit or tag shows up at the ports on the very next read of that index. It appears as a zero-cycle completion with no memory request, where the bench expects a fetch, or as wrong data. A valid bit lost by mistake shows up the other way, as an unexpected memory request. A wrong region register or a sweep of the wrong length shows up as a busy count other than 2^IDX_W on the access that crosses regions, or as hits right after a region change. The bench keeps a line-by-line model and compares hit or miss, data, busy length and memory traffic on every access. Most internal faults therefore show up within one access of the fault.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SWEEP = 2'd1,
    ST_FETCH = 2'd2,
    ST_WRITE = 2'd3
  } dmc_state_e;
endpackage

// File: rtl/dmc_addr_split.sv
module dmc_addr_split #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 10,
  parameter int TAG_W  = 8,
  parameter int REG_W  = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [REG_W-1:0]  region_o,
  output logic [ADDR_W-3:0] word_o
);
  localparam int IDX_LO = 2;
  localparam int TAG_LO = IDX_LO + IDX_W;
  localparam int REG_LO = TAG_LO + TAG_W;
  localparam int USED_W = REG_LO + REG_W;

  assign idx_o    = addr_i[TAG_LO-1:IDX_LO];
  assign tag_o    = addr_i[REG_LO-1:TAG_LO];
  assign region_o = addr_i[USED_W-1:REG_LO];
  assign word_o   = addr_i[ADDR_W-1:2];

  // bits above the region field are unused for lookup
  generate
    if (ADDR_W > USED_W) begin : g_spare
      logic [ADDR_W-USED_W-1:0] spare_unused;
      assign spare_unused = addr_i[ADDR_W-1:USED_W];
    end
  endgenerate

  logic [1:0] ofs_unused;
  assign ofs_unused = addr_i[1:0];
endmodule

// File: rtl/dmc_line_store.sv
module dmc_line_store #(
  parameter int IDX_W  = 10,
  parameter int TAG_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_valid_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              clr_i,
  input  logic [IDX_W-1:0]  clr_idx_i,
  input  logic              fill_i,
  input  logic              upd_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [DATA_W-1:0] wr_data_i
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0]  valid_q;
  logic [LINES-1:0]  valid_d;
  logic [TAG_W-1:0]  tag_mem  [LINES];
  logic [DATA_W-1:0] data_mem [LINES];

  generate
    for (genvar i = 0; i < LINES; i++) begin : g_vld
      assign valid_d[i] = (clr_i && clr_idx_i == IDX_W'(i)) ? 1'b0 :
                          (fill_i && wr_idx_i == IDX_W'(i)) ? 1'b1 : valid_q[i];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= '0;
    else         valid_q <= valid_d;
  end

  always_ff @(posedge clk_i) begin
    if (fill_i) begin
      tag_mem[wr_idx_i]  <= wr_tag_i;
      data_mem[wr_idx_i] <= wr_data_i;
    end else if (upd_i) begin
      data_mem[wr_idx_i] <= wr_data_i;
    end
  end

  assign rd_valid_o = valid_q[rd_idx_i];
  assign rd_tag_o   = tag_mem[rd_idx_i];
  assign rd_data_o  = data_mem[rd_idx_i];

  AST_FILL_SETS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i && !clr_i) |=> valid_q[$past(wr_idx_i)]); // R3
  AST_SWEEP_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !valid_q[$past(clr_idx_i)]); // R5
  AST_UPD_KEEPS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !fill_i && !clr_i) |=> valid_q == $past(valid_q)); // R9
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
  import dmc_pkg::*;
#(
  parameter int IDX_W = 10,
  parameter int REG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [REG_W-1:0] region_i,
  input  logic             hit_i,
  input  logic             mem_ack_i,
  output logic             ready_o,
  output logic             busy_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic             rd_from_mem_o,
  output logic             fill_o,
  output logic             upd_o,
  output logic             clr_o,
  output logic [IDX_W-1:0] clr_idx_o
);
  localparam int LINES = 1 << IDX_W;

  dmc_state_e       state_q, state_d;
  logic [IDX_W-1:0] sweep_q;
  logic [REG_W-1:0] region_q;
  logic             region_vld_q;
  logic             region_ok;
  logic             sweep_last;
  logic             load_region;

  assign region_ok  = !region_vld_q || (region_q == region_i);
  assign sweep_last = (sweep_q == {IDX_W{1'b1}});

  always_comb begin
    state_d       = state_q;
    ready_o       = 1'b0;
    mem_req_o     = 1'b0;
    mem_we_o      = 1'b0;
    rd_from_mem_o = 1'b0;
    fill_o        = 1'b0;
    upd_o         = 1'b0;
    clr_o         = 1'b0;
    load_region   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_i) begin
          load_region = !region_vld_q;
          if (!region_ok)  state_d = ST_SWEEP;
          else if (we_i)   state_d = ST_WRITE;
          else if (hit_i)  ready_o = 1'b1;
          else             state_d = ST_FETCH;
        end
      end
      ST_SWEEP: begin
        clr_o = 1'b1;
        if (sweep_last) begin
          load_region = 1'b1;
          state_d     = ST_IDLE;
        end
      end
      ST_FETCH: begin
        mem_req_o     = 1'b1;
        rd_from_mem_o = 1'b1;
        if (mem_ack_i) begin
          fill_o  = 1'b1;
          ready_o = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_WRITE: begin
        mem_req_o = 1'b1;
        mem_we_o  = 1'b1;
        if (mem_ack_i) begin
          upd_o   = hit_i;
          ready_o = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign busy_o    = (state_q == ST_SWEEP);
  assign clr_idx_o = sweep_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      sweep_q      <= '0;
      region_q     <= '0;
      region_vld_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (clr_o) sweep_q <= sweep_q + 1'b1;
      if (load_region) begin
        region_q     <= region_i;
        region_vld_q <= 1'b1;
      end
    end
  end

  // sweep length monitor
  logic [IDX_W:0] busy_len_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_len_q <= '0;
    else if (busy_o) busy_len_q <= busy_len_q + 1'b1;
    else             busy_len_q <= '0;
  end

  AST_MEM_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> mem_req_o); // R2
  AST_SWEEP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (!mem_req_o && !ready_o)); // R5
  AST_SWEEP_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> busy_len_q == (IDX_W+1)'(LINES)); // R5
  AST_LOCAL_DONE_IS_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !mem_req_o) |-> (!we_i && hit_i)); // R1
  AST_WRITE_THROUGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && we_i) |-> (mem_ack_i && mem_we_o)); // R7
endmodule

// File: rtl/dm_region_cache.sv
module dm_region_cache #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 10,
  parameter int TAG_W  = 8,
  parameter int REG_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ready_o,
  output logic              busy_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-3:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ack_i
);
  logic [IDX_W-1:0]  a_idx;
  logic [TAG_W-1:0]  a_tag;
  logic [REG_W-1:0]  a_region;
  logic [ADDR_W-3:0] a_word;
  logic              line_valid;
  logic [TAG_W-1:0]  line_tag;
  logic [DATA_W-1:0] line_data;
  logic              hit;
  logic              rd_from_mem;
  logic              fill, upd, clr;
  logic [IDX_W-1:0]  clr_idx;
  logic [DATA_W-1:0] store_wdata;

  dmc_addr_split #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .REG_W(REG_W)
  ) u_split (
    .addr_i  (addr_i),
    .idx_o   (a_idx),
    .tag_o   (a_tag),
    .region_o(a_region),
    .word_o  (a_word)
  );

  dmc_line_store #(
    .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
  ) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_idx_i  (a_idx),
    .rd_valid_o(line_valid),
    .rd_tag_o  (line_tag),
    .rd_data_o (line_data),
    .clr_i     (clr),
    .clr_idx_i (clr_idx),
    .fill_i    (fill),
    .upd_i     (upd),
    .wr_idx_i  (a_idx),
    .wr_tag_i  (a_tag),
    .wr_data_i (store_wdata)
  );

  assign hit = line_valid && (line_tag == a_tag);

  dmc_ctrl #(
    .IDX_W(IDX_W), .REG_W(REG_W)
  ) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (req_i),
    .we_i         (we_i),
    .region_i     (a_region),
    .hit_i        (hit),
    .mem_ack_i    (mem_ack_i),
    .ready_o      (ready_o),
    .busy_o       (busy_o),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .rd_from_mem_o(rd_from_mem),
    .fill_o       (fill),
    .upd_o        (upd),
    .clr_o        (clr),
    .clr_idx_o    (clr_idx)
  );

  assign store_wdata = fill ? mem_rdata_i : wdata_i;
  assign rdata_o     = rd_from_mem ? mem_rdata_i : line_data;
  assign mem_addr_o  = a_word;
  assign mem_wdata_o = wdata_i;

  AST_FILL_RETURNS_MEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && mem_req_o && !mem_we_o) |-> rdata_o == mem_rdata_i); // R2
  AST_NO_FILL_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> !fill); // R9
  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> (!ready_o && !busy_o && !mem_req_o)); // R10
endmodule

// File: tb/dm_region_cache_tb_top.sv
module dm_region_cache_tb_top;
  localparam int IW    = 4;
  localparam int LINES = 1 << IW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [31:0] addr = '0, wdata = '0;
  logic [31:0] rdata;
  logic        ready, busy, mreq, mwe;
  logic [29:0] maddr;
  logic [31:0] mwdata;
  logic [31:0] mrdata = '0;
  logic        mack = 1'b0;

  int total = 0, bad = 0, cyc = 0;

  always #4 clk = ~clk;  // 125 MHz

  dm_region_cache #(.IDX_W(IW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .ready_o(ready), .busy_o(busy),
    .mem_req_o(mreq), .mem_we_o(mwe), .mem_addr_o(maddr),
    .mem_wdata_o(mwdata), .mem_rdata_i(mrdata), .mem_ack_i(mack)
  );

  // requirement-level model
  logic [31:0] bmem [int];
  logic        m_valid [LINES];
  logic [7:0]  m_tag   [LINES];
  logic [31:0] m_data  [LINES];
  logic [7:0]  m_reg;
  logic        m_rvld;

  function automatic logic [31:0] backing(logic [31:0] a);
    int k = int'(a[31:2]);
    if (bmem.exists(k)) return bmem[k];
    return (a[31:2] * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic [31:0] mk(logic [7:0] rg, logic [7:0] tg,
                                     logic [3:0] ix, logic [1:0] of, logic [9:0] hi);
    return {hi, rg, tg, ix, of};
  endfunction

  task automatic chk(bit ok, string rq, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // one processor access; returns observed behaviour
  task automatic access(input bit w, input logic [31:0] a, input logic [31:0] wd,
                        output logic [31:0] rd, output bit used_mem, output int busy_n,
                        output bit addr_ok, output bit we_ok);
    int  wait_n = 0;
    int  lat = int'(a[3:2]) % 3;
    bit  done = 0;
    used_mem = 0; busy_n = 0; addr_ok = 1; we_ok = 1; rd = '0;
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = wd;
    for (int guard = 0; guard < 400 && !done; guard++) begin
      #1;
      if (busy) busy_n++;
      if (mreq) begin
        used_mem = 1;
        if (maddr != a[31:2]) addr_ok = 0;
        if (mwe != w || (w && mwdata != wd)) we_ok = 0;
        if (wait_n == lat) begin
          mack = 1'b1;
          mrdata = w ? 32'hDEAD_BEEF : backing(a);
          if (w) bmem[int'(a[31:2])] = wd;
        end
        wait_n++;
      end
      #1;
      if (ready) begin done = 1; rd = rdata; end
      @(negedge clk);
      mack = 1'b0;
    end
    req = 1'b0;
    if (!done) chk(0, "R2", "access never completed", 0, 1);
  endtask

  // run access and compare with model; lbl names the requirement under test
  task automatic run(input bit w, input logic [31:0] a, input logic [31:0] wd, input string lbl);
    logic [31:0] rd, exp_d;
    bit used, aok, wok, flush, hit;
    int bn;
    logic [3:0] ix = a[5:2];
    logic [7:0] tg = a[13:6];
    logic [7:0] rg = a[21:14];
    flush = m_rvld && (m_reg != rg);
    if (flush) foreach (m_valid[i]) m_valid[i] = 0;
    m_reg = rg; m_rvld = 1;
    hit = m_valid[ix] && m_tag[ix] == tg;
    exp_d = hit ? m_data[ix] : backing(a);
    access(w, a, wd, rd, used, bn, aok, wok);
    chk(bn == (flush ? LINES : 0), flush ? "R5" : "R6", "busy cycles", bn, flush ? LINES : 0);
    if (w) begin
      chk(used, "R7", "write reached memory", used, 1);
      chk(wok, "R7", "write strobe/data", wok, 1);
      if (hit) m_data[ix] = wd;
    end else begin
      chk(used == !hit, lbl, hit ? "hit expected" : "miss expected", used, !hit);
      chk(rd == exp_d, lbl, "read data", rd, exp_d);
      if (!hit) begin m_valid[ix] = 1; m_tag[ix] = tg; m_data[ix] = exp_d; end
    end
    if (used) chk(aok, "R2", "memory word address", aok, 1);
  endtask

  initial begin
    logic [31:0] a0, a1;
    m_rvld = 0; m_reg = '0;
    foreach (m_valid[i]) begin m_valid[i] = 0; m_tag[i] = '0; m_data[i] = '0; end
    repeat (3) @(negedge clk);
    chk(!ready && !busy && !mreq, "R10", "outputs in reset", {ready, busy, mreq}, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!ready && !busy && !mreq, "R10", "outputs after reset", {ready, busy, mreq}, 0);

    // first access: region load without sweep, miss
    run(0, mk(8'h05, 8'h03, 4'd0, 2'd0, 10'd0), 0, "R6");
    // fill every index, then re-read with other offsets/high bits
    for (int i = 0; i < LINES; i++) run(0, mk(8'h05, 8'h03, 4'(i), 2'd1, 10'd7), 0, "R2");
    for (int i = 0; i < LINES; i++)
      for (int o = 0; o < 4; o++) run(0, mk(8'h05, 8'h03, 4'(i), 2'(o), 10'(i * 37 + o)), 0, "R11");
    for (int i = 0; i < LINES; i++) run(0, mk(8'h05, 8'h03, 4'(i), 2'd0, 10'd0), 0, "R3");
    // conflict pair
    a0 = mk(8'h05, 8'h01, 4'd7, 2'd0, 10'd0);
    a1 = mk(8'h05, 8'h02, 4'd7, 2'd0, 10'd0);
    for (int k = 0; k < 4; k++) begin run(0, a0, 0, "R4"); run(0, a1, 0, "R4"); end
    // write hit then read
    run(1, mk(8'h05, 8'h03, 4'd2, 2'd0, 10'd0), 32'hCAFE_0002, "R7");
    run(0, mk(8'h05, 8'h03, 4'd2, 2'd3, 10'd0), 0, "R8");
    // write miss then read
    run(1, mk(8'h05, 8'h09, 4'd3, 2'd0, 10'd0), 32'hCAFE_0903, "R7");
    run(0, mk(8'h05, 8'h09, 4'd3, 2'd0, 10'd0), 0, "R9");
    // region change: sweep, everything misses
    run(0, mk(8'h06, 8'h03, 4'd0, 2'd0, 10'd0), 0, "R5");
    for (int i = 1; i < LINES; i++) run(0, mk(8'h06, 8'h03, 4'(i), 2'd0, 10'd0), 0, "R5");
    // mixed random traffic
    for (int n = 0; n < 600; n++) begin
      logic [31:0] r = $urandom;
      logic [7:0]  rg = (r[31:27] == 0) ? 8'(r[26]) + 8'h05 : m_reg;
      run(r[25:23] == 0, mk(rg, 8'(r[22:21]), r[20:17], r[16:15], r[9:0]), $urandom, "R1");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule